// File: doc/BRIEF.md
# Indirect Configuration Table Access Controller

The block gives a host processor access to two internal configuration tables through a small register window on a 32-bit register bus. One table has 32 scheme entries of 23 words each; the other has 64 port entries, each with two partition words (a scheme-binding word and a classification-plan word). The host never addresses the tables directly. It loads a staging window of 23 words at byte offsets 0x100 to 0x158, then writes a command word to the action register at offset 0x1FC. The command names the target table, the entry, the direction and, for port entries, which of the two words to move.

Setting the go bit in the command starts a transfer. The controller either copies staging into the selected entry (write) or copies the entry into staging (read), one word per clock. When it is done it clears go, and sets an error flag if the command was rejected. Software polls go until it reads 0 and then inspects the error bit. To bind port P to scheme n, software reads the port's binding word into staging, sets bit (31 - n) in staging word 0, and writes it back. The controller only stores and moves words; the meaning of the bits belongs to software.

Top module: `tbl_window_ctl`

## Requirements
- R1: After reset, go and error read 0, all other action fields read 0, all staging words read 0, and every scheme and port table word is 0.
- R2: The action register at byte offset 0x1FC reads back as: go in bit 31, direction in bit 30, error in bit 29, target in bits 25:24, entry index in bits 23:16, word selects in bits 15:14, port number in bits 7:0. All other bits read 0. Writing the register with bit 31 set while go is 0 starts a transfer.
- R3: Direction bit 30 = 1 copies entry to staging. Bit 30 = 0 copies staging to entry. Scheme word k maps to staging byte offset 0x100 + 4k, for k from 0 to 22.
- R4: Go reads 1 for a fixed number of clock edges after the command-write edge and then reads 0: 23 edges for a scheme transfer, 2 for a port transfer, and 1 for a rejected command.
- R5: Target code 00 in bits 25:24 selects scheme entry bits 23:16. Target code 10 selects port entry bits 7:0.
- R6: For a port target, bit 15 moves the scheme-binding word to or from staging word 0 (0x100), and bit 14 moves the classification-plan word to or from staging word 1 (0x104). A word whose select bit is clear is left unchanged both in the table and in staging.
- R7: A scheme write with bit 15 clear leaves scheme word 16 (the counter word, staging offset 0x140) unchanged. With bit 15 set, that word is written like the others. Scheme reads always return word 16.
- R8: These commands set the error flag, change no table or staging word, and finish after one edge: a scheme index of 32 or more, a port number of 64 or more, target code 01, or target code 11.
- R9: The error flag stays set through action writes that have bit 31 clear; such writes update only the readable fields. The next command with bit 31 set clears the flag, or sets it again if that command is itself rejected.
- R10: While go is 1, bus writes to staging words and to the action register are ignored.
- R11: Reads and writes at offsets outside the staging words and the action register have no effect, and such reads return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 9 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |

## Verification
Read data is combinational, so a value written at an edge is visible on the next read after that edge. After each command-write edge, go is due to fall 23 edges later for a scheme, 2 for a port and 1 for a rejected command. The bench samples the action register one nanosecond after every falling edge and counts how many samples show go still set, then compares that count with the expected length. Staging contents and the error bit are compared only after go is observed clear, and a busy-window test issues bus writes on the edges right after a command to confirm that they are dropped.

// File: rtl/tbl_window_ctl.sv
module tbl_window_ctl #(
  parameter int SCH_ENTRIES  = 32,
  parameter int SCH_WORDS    = 23,
  parameter int PORT_ENTRIES = 64,
  parameter int CNT_WORD     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [8:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int SW = $clog2(SCH_WORDS);
  localparam int IW = $clog2(SCH_ENTRIES);
  localparam int PW = $clog2(PORT_ENTRIES);
  localparam int EW = $clog2(SCH_ENTRIES * SCH_WORDS);
  localparam logic [8:0]    ACT_ADDR  = 9'h1FC;
  localparam logic [5:0]    WIN_WORDS = 6'(SCH_WORDS);
  localparam logic [7:0]    SCH_LIM   = 8'(SCH_ENTRIES);
  localparam logic [7:0]    PORT_LIM  = 8'(PORT_ENTRIES);
  localparam logic [SW-1:0] CNT_SLOT  = SW'(CNT_WORD);
  localparam logic [SW-1:0] SCH_LAST  = SW'(SCH_WORDS - 1);

  logic go, err, c_rd;
  logic [1:0] c_tgt, c_wsel;
  logic [7:0] c_idx, c_port;
  logic [SW-1:0] cnt;

  logic [31:0] stg     [SCH_WORDS];
  logic [31:0] sch_mem [SCH_ENTRIES*SCH_WORDS];
  logic [31:0] sp_mem  [PORT_ENTRIES];
  logic [31:0] cpp_mem [PORT_ENTRIES];

  logic [5:0] win_idx;
  logic [SW-1:0] win_sel, cnt_last;
  logic win_hit, act_hit, cmd_wr, new_bad, is_port, unused_bits;
  logic [EW-1:0] eidx;
  logic [PW-1:0] pidx;
  logic [31:0] act_rd;

  assign win_idx  = bus_addr[7:2];
  assign win_sel  = win_idx[SW-1:0];
  assign win_hit  = bus_addr[8] && (win_idx < WIN_WORDS);
  assign act_hit  = (bus_addr == ACT_ADDR);
  assign cmd_wr   = bus_wr && act_hit && !go;
  assign new_bad  = (bus_wdata[25:24] == 2'b01) || (bus_wdata[25:24] == 2'b11) ||
                    ((bus_wdata[25:24] == 2'b00) && (bus_wdata[23:16] >= SCH_LIM)) ||
                    ((bus_wdata[25:24] == 2'b10) && (bus_wdata[7:0] >= PORT_LIM));
  assign is_port  = c_tgt[1];
  assign cnt_last = is_port ? SW'(1) : SCH_LAST;
  assign eidx     = EW'(c_idx[IW-1:0]) * EW'(SCH_WORDS) + EW'(cnt);
  assign pidx     = c_port[PW-1:0];
  assign act_rd   = {go, c_rd, err, 3'b000, c_tgt, c_idx, c_wsel, 6'b000000, c_port};
  assign bus_rdata = act_hit ? act_rd : (win_hit ? stg[win_sel] : 32'h0);
  assign unused_bits = ^{bus_wdata[29:26], bus_wdata[13:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go     <= 1'b0;
      err    <= 1'b0;
      c_rd   <= 1'b0;
      c_tgt  <= 2'b00;
      c_wsel <= 2'b00;
      c_idx  <= 8'h00;
      c_port <= 8'h00;
      cnt    <= '0;
    end else if (cmd_wr) begin
      c_rd   <= bus_wdata[30];
      c_tgt  <= bus_wdata[25:24];
      c_idx  <= bus_wdata[23:16];
      c_wsel <= bus_wdata[15:14];
      c_port <= bus_wdata[7:0];
      cnt    <= '0;
      if (bus_wdata[31]) begin
        go  <= 1'b1;
        err <= new_bad;
      end
    end else if (go) begin
      if (err || cnt == cnt_last) go <= 1'b0;
      cnt <= cnt + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SCH_WORDS; i++) stg[i] <= '0;
      for (int i = 0; i < SCH_ENTRIES*SCH_WORDS; i++) sch_mem[i] <= '0;
      for (int i = 0; i < PORT_ENTRIES; i++) begin
        sp_mem[i]  <= '0;
        cpp_mem[i] <= '0;
      end
    end else begin
      if (bus_wr && win_hit && !go) stg[win_sel] <= bus_wdata;
      if (go && !err) begin
        if (!is_port) begin
          if (c_rd) stg[cnt] <= sch_mem[eidx];
          else if (cnt != CNT_SLOT || c_wsel[1]) sch_mem[eidx] <= stg[cnt];
        end else if (cnt[0] ? c_wsel[0] : c_wsel[1]) begin
          if (c_rd) stg[cnt] <= cnt[0] ? cpp_mem[pidx] : sp_mem[pidx];
          else if (cnt[0]) cpp_mem[pidx] <= stg[1];
          else sp_mem[pidx] <= stg[0];
        end
      end
    end
  end
endmodule

// File: rtl/tbl_window_ctl_chk.sv
module tbl_window_ctl_chk #(
  parameter int SCH_WORDS = 23
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [8:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        go,
  input logic        err,
  input logic [20:0] fields
);
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else run_len <= go ? run_len + 16'd1 : 16'd0;
  end

  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && bus_wr && bus_addr == 9'h1FC && bus_wdata[31]) |=> go); // R2
  AST_GO_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (run_len < 16'(SCH_WORDS))); // R4
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (go && err) |=> !go); // R8
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(bus_wr && bus_addr == 9'h1FC && bus_wdata[31])); // R9
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> $stable(fields)); // R10
endmodule

bind tbl_window_ctl tbl_window_ctl_chk #(.SCH_WORDS(SCH_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .go(go), .err(err),
  .fields({c_rd, c_tgt, c_idx, c_wsel, c_port})
);

// File: tb/sim_tbl_window_ctl.sv
module sim_tbl_window_ctl;
  localparam int NS = 32, NW = 23, NP = 64, CW = 16;
  localparam logic [8:0] ACT = 9'h1FC;
  localparam logic [31:0] FMASK = 32'h43FFC0FF;
  localparam logic [31:0] GO = 32'h8000_0000, RD = 32'h4000_0000;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  wire  [31:0] bus_rdata;
  always #5 clk = ~clk;

  tbl_window_ctl u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                     .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int total = 0, fails = 0;
  logic [31:0] m_sch [NS][NW];
  logic [31:0] m_sp [NP], m_cpp [NP], m_stg [NW];
  logic m_err;
  logic [31:0] m_act;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [8:0] stg_addr(input int k);
    return 9'(256 + 4 * k);
  endfunction

  function automatic bit cmd_bad(input logic [31:0] c);
    return (c[25:24] == 2'b01) || (c[25:24] == 2'b11) ||
           (c[25:24] == 2'b00 && c[23:16] >= NS) || (c[25:24] == 2'b10 && c[7:0] >= NP);
  endfunction

  function automatic int cmd_len(input logic [31:0] c);
    if (cmd_bad(c)) return 1;
    return c[25] ? 2 : NW;
  endfunction

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic model_cmd(input logic [31:0] c);
    m_err = cmd_bad(c);
    m_act = c & FMASK;
    if (m_err) return;
    if (c[25] == 1'b0) begin
      for (int k = 0; k < NW; k++)
        if (c[30]) m_stg[k] = m_sch[c[23:16]][k];
        else if (k != CW || c[15]) m_sch[c[23:16]][k] = m_stg[k];
    end else begin
      if (c[15]) begin
        if (c[30]) m_stg[0] = m_sp[c[7:0]]; else m_sp[c[7:0]] = m_stg[0];
      end
      if (c[14]) begin
        if (c[30]) m_stg[1] = m_cpp[c[7:0]]; else m_cpp[c[7:0]] = m_stg[1];
      end
    end
  endtask

  task automatic stg_write(input int k, input logic [31:0] d);
    bus_write(stg_addr(k), d);
    m_stg[k] = d;
  endtask

  task automatic run_cmd(input logic [31:0] c);
    int n;
    logic [31:0] r;
    bus_write(ACT, c | GO);
    model_cmd(c);
    n = 0;
    bus_addr = ACT;
    #1;
    while (bus_rdata[31]) begin
      n++;
      @(negedge clk);
      #1;
    end
    check("R4", 32'(n), 32'(cmd_len(c)), "go duration");
    bus_read(ACT, r);
    check("R2", r & FMASK, m_act, "action fields");
    check("R8", {31'b0, r[29]}, {31'b0, m_err}, "error flag");
  endtask

  task automatic verify_stg(input string req);
    logic [31:0] r;
    for (int k = 0; k < NW; k++) begin
      bus_read(stg_addr(k), r);
      check(req, r, m_stg[k], $sformatf("staging word %0d", k));
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r, c;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NS; i++) for (int k = 0; k < NW; k++) m_sch[i][k] = '0;
    for (int i = 0; i < NP; i++) begin m_sp[i] = '0; m_cpp[i] = '0; end
    for (int k = 0; k < NW; k++) m_stg[k] = '0;
    m_err = 0; m_act = '0;

    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_read(ACT, r);
    check("R1", r, 32'h0, "action after reset");
    verify_stg("R1");
    run_cmd(RD | (32'd5 << 16));
    verify_stg("R1");
    run_cmd(RD | 32'h0200_C000 | 32'd9);
    verify_stg("R1");

    // R3 scheme write then read, with counter update (R7)
    for (int k = 0; k < NW; k++) stg_write(k, 32'hA500_0000 ^ (32'h0101_0101 * k));
    run_cmd((32'd3 << 16) | 32'h0000_8000);
    for (int k = 0; k < NW; k++) stg_write(k, 32'h5A5A_0000 + k);
    run_cmd(RD | (32'd3 << 16));
    verify_stg("R3");

    // R7 counter word kept when update bit clear
    for (int k = 0; k < NW; k++) stg_write(k, 32'hC0DE_0000 + k);
    run_cmd(32'd3 << 16);
    run_cmd(RD | (32'd3 << 16));
    verify_stg("R7");
    run_cmd(32'd31 << 16);
    run_cmd(RD | (32'd31 << 16));
    verify_stg("R5");

    // R6 port word selects and bind read-modify-write
    stg_write(0, 32'h1 << (31 - 3));
    stg_write(1, 32'h0000_1234);
    run_cmd(32'h0200_8000 | 32'd7);
    stg_write(0, 32'hFFFF_FFFF);
    stg_write(1, 32'hEEEE_EEEE);
    run_cmd(RD | 32'h0200_C000 | 32'd7);
    verify_stg("R6");
    stg_write(0, m_stg[0] | (32'h1 << (31 - 9)));
    run_cmd(32'h0200_8000 | 32'd7);
    run_cmd(RD | 32'h0200_8000 | 32'd7);
    verify_stg("R6");
    stg_write(1, 32'h0000_00AB);
    run_cmd(32'h0200_4000 | 32'd63);
    run_cmd(RD | 32'h0200_C000 | 32'd63);
    verify_stg("R6");

    // R8 rejected commands
    run_cmd(32'd32 << 16);
    run_cmd(32'h0200_C000 | 32'd64);
    run_cmd(32'h0100_0000);
    run_cmd(RD | 32'h0300_0000);
    run_cmd(RD | (32'd3 << 16));
    verify_stg("R8");

    // R9 error sticky through non-go writes, cleared by next go
    run_cmd(32'd40 << 16);
    bus_write(ACT, 32'h4212_80FF);
    m_act = 32'h4212_80FF & FMASK;
    bus_read(ACT, r);
    check("R9", r, m_act | 32'h2000_0000, "non-go write keeps error");
    run_cmd(RD | (32'd1 << 16));
    bus_read(ACT, r);
    check("R9", {31'b0, r[29]}, 32'h0, "error cleared by go");

    // R10 writes ignored while busy
    c = (32'd2 << 16) | 32'h0000_8000;
    bus_write(ACT, c | GO);
    model_cmd(c);
    bus_write(stg_addr(3), 32'hDEAD_BEEF);
    bus_write(ACT, GO | RD | 32'h0200_C000 | 32'd1);
    repeat (30) @(negedge clk);
    bus_read(stg_addr(3), r);
    check("R10", r, m_stg[3], "staging write during busy");
    bus_read(ACT, r);
    check("R10", r, m_act, "action write during busy");
    run_cmd(RD | (32'd2 << 16));
    verify_stg("R10");

    // R11 out-of-window accesses
    bus_write(9'h15C, 32'h1111_2222);
    bus_write(9'h00C, 32'h3333_4444);
    bus_read(9'h15C, r);
    check("R11", r, 32'h0, "read past staging");
    bus_read(9'h00C, r);
    check("R11", r, 32'h0, "read low offset");
    verify_stg("R11");

    // R5 random mix
    for (int it = 0; it < 300; it++) begin
      if ($urandom % 2 == 0) begin
        stg_write($urandom % NW, $urandom);
      end else begin
        int t;
        logic [31:0] cc;
        t = $urandom % 8;
        cc = {1'b0, 1'($urandom), 6'($urandom) & 6'h00, 8'h00, 2'($urandom), 6'($urandom), 8'h00};
        if (t < 4) cc[25:24] = 2'b00;
        else if (t < 7) cc[25:24] = 2'b10;
        else cc[25:24] = ($urandom % 2) ? 2'b01 : 2'b11;
        cc[23:16] = 8'($urandom % 40);
        cc[7:0] = 8'($urandom % 72);
        run_cmd(cc);
      end
      if (it % 25 == 24) verify_stg("R5");
    end

    // R5 full table dump
    for (int i = 0; i < NS; i++) begin
      run_cmd(RD | (32'(i) << 16));
      verify_stg("R5");
    end
    for (int p = 0; p < NP; p++) begin
      run_cmd(RD | 32'h0200_C000 | 32'(p));
      bus_read(stg_addr(0), r);
      check("R5", r, m_sp[p], "port binding word");
      bus_read(stg_addr(1), r);
      check("R5", r, m_cpp[p], "port plan word");
    end

    summary();
    $finish;
  end
endmodule